// File: doc/BRIEF.md
# Frame-Stepped Drawing Cursor

This block keeps the position of a drawing cursor on a 1280 by 1024 pixel grid. A pulse from the video timing logic, one clock wide and issued once per frame at the start of vertical blanking, is the only event that moves the cursor. On each such pulse every axis steps by exactly one pixel in the direction chosen by its direction switch, or stays where it is if its stop switch is set. Because motion is bound to the frame rate, the speed on screen is the same whatever the pixel clock is.

When an axis steps past the last pixel it comes back at the first one, and the reverse also holds, so the cursor never stops at an edge. A recentre switch puts the cursor back in the middle of the screen on the next clock edge. It does not wait for a frame pulse, and it wins over any motion requested in the same cycle. Switch debouncing and the generation of the frame pulse are left to the logic around the block.

Top module: `cursor_frame_stepper`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cur_x` reads 640 and `cur_y` reads 512.
- R2: With `recenter` high at a rising clock edge, the next cycle shows `cur_x`=640 and `cur_y`=512, whatever `frame_tick`, the direction switches or the stop switches are doing.
- R3: With `frame_tick` low and `recenter` low, neither coordinate changes at a clock edge.
- R4: On a clock edge with `frame_tick` high, `recenter` low and the axis stop switch low, a direction switch at 1 raises that coordinate by one.
- R5: On such an edge a direction switch at 0 lowers that coordinate by one.
- R6: The horizontal coordinate steps from 1279 to 0 when increasing and from 0 to 1279 when decreasing.
- R7: The vertical coordinate steps from 1023 to 0 when increasing and from 0 to 1023 when decreasing.
- R8: A stop switch at 1 holds its own axis through a frame pulse, and the other axis still steps.
- R9: `cur_x` is always below 1280 and `cur_y` is always below 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads the centre |
| frame_tick | input | 1 | One-cycle pulse per frame that allows one step |
| dir_x | input | 1 | 1 moves right, 0 moves left |
| dir_y | input | 1 | 1 moves down, 0 moves up |
| hold_x | input | 1 | 1 stops horizontal motion |
| hold_y | input | 1 | 1 stops vertical motion |
| recenter | input | 1 | 1 returns the cursor to the centre on the next edge |
| cur_x | output | 11 | Horizontal cursor coordinate, 0 to 1279 |
| cur_y | output | 10 | Vertical cursor coordinate, 0 to 1023 |

## Verification
A corrupt coordinate register shows on `cur_x` or `cur_y` straight away, because the outputs are the registers themselves. A fault in the step decision shows only on the edge that carries `frame_tick`, so each check samples one cycle after a pulse. Faults at the wrap boundary stay hidden until the cursor is driven all the way to an edge, so the bench walks each axis to both limits and crosses them. A recentre that waits for the frame pulse shows up one cycle after `recenter` is raised with no pulse present.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_HOME = 2'd3
    } step_e;
endpackage

// File: rtl/cursor_step_pick.sv
module cursor_step_pick
    import cursor_pkg::*;
(
    input  logic  frame_tick,
    input  logic  dir_up,
    input  logic  hold,
    input  logic  recenter,
    output step_e action
);
    always_comb begin
        if (recenter)
            action = STEP_HOME;
        else if (!frame_tick || hold)
            action = STEP_KEEP;
        else if (dir_up)
            action = STEP_UP;
        else
            action = STEP_DOWN;
    end
endmodule

// File: rtl/cursor_axis.sv
module cursor_axis
    import cursor_pkg::*;
#(
    parameter int SPAN = 1280,
    parameter int HOME = SPAN / 2,
    localparam int W = $clog2(SPAN)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_tick,
    input  logic         dir_up,
    input  logic         hold,
    input  logic         recenter,
    output logic [W-1:0] pos
);
    localparam logic [W-1:0] LAST   = W'(SPAN - 1);
    localparam logic [W-1:0] CENTRE = W'(HOME);

    typedef struct packed {
        logic [W-1:0] pos;
    } axis_state_t;

    axis_state_t state_d, state_q;
    step_e       action;

    cursor_step_pick u_pick (
        .frame_tick (frame_tick),
        .dir_up     (dir_up),
        .hold       (hold),
        .recenter   (recenter),
        .action     (action)
    );

    always_comb begin
        state_d = state_q;
        unique case (action)
            STEP_HOME: state_d.pos = CENTRE;
            STEP_UP:   state_d.pos = (state_q.pos == LAST) ? '0 : state_q.pos + W'(1);
            STEP_DOWN: state_d.pos = (state_q.pos == '0) ? LAST : state_q.pos - W'(1);
            default:   state_d.pos = state_q.pos;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '{pos: CENTRE};
        else
            state_q <= state_d;
    end

    assign pos = state_q.pos;

    p_centre_r2: assert property (@(posedge clk) disable iff (!rst_n)
        recenter |=> pos == CENTRE);

    p_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!recenter && !frame_tick) |=> $stable(pos));

    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !recenter && !hold && dir_up && pos != LAST)
            |=> pos == $past(pos) + W'(1));

    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !recenter && !hold && !dir_up && pos != '0)
            |=> pos == $past(pos) - W'(1));

    p_wrap_high_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !recenter && !hold && dir_up && pos == LAST) |=> pos == '0);

    p_wrap_low_r6_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !recenter && !hold && !dir_up && pos == '0) |=> pos == LAST);

    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !recenter) |=> $stable(pos));

    p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST);
endmodule

// File: rtl/cursor_frame_stepper.sv
module cursor_frame_stepper #(
    parameter int H_PIXELS = 1280,
    parameter int V_LINES  = 1024,
    localparam int XW = $clog2(H_PIXELS),
    localparam int YW = $clog2(V_LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          dir_x,
    input  logic          dir_y,
    input  logic          hold_x,
    input  logic          hold_y,
    input  logic          recenter,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y
);
    cursor_axis #(.SPAN(H_PIXELS), .HOME(H_PIXELS / 2)) u_axis_x (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .dir_up     (dir_x),
        .hold       (hold_x),
        .recenter   (recenter),
        .pos        (cur_x)
    );

    cursor_axis #(.SPAN(V_LINES), .HOME(V_LINES / 2)) u_axis_y (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .dir_up     (dir_y),
        .hold       (hold_y),
        .recenter   (recenter),
        .pos        (cur_y)
    );

    p_reset_r1: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (cur_x == XW'(H_PIXELS / 2) && cur_y == YW'(V_LINES / 2)));
endmodule

// File: tb/tb_cursor_frame_stepper.sv
module tb_cursor_frame_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        dir_x = 1'b1;
    logic        dir_y = 1'b1;
    logic        hold_x = 1'b0;
    logic        hold_y = 1'b0;
    logic        recenter = 1'b0;
    logic [10:0] cur_x;
    logic [9:0]  cur_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cursor_frame_stepper dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .dir_x(dir_x), .dir_y(dir_y), .hold_x(hold_x), .hold_y(hold_y),
        .recenter(recenter), .cur_x(cur_x), .cur_y(cur_y)
    );

    task automatic check(input string req, input int got, input int want);
        checks++;
        if (got != want) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) frame_tick = 1'b1;
            @(negedge clk) frame_tick = 1'b0;
        end
    endtask

    task automatic do_recentre();
        @(negedge clk) recenter = 1'b1;
        @(negedge clk) recenter = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 x in reset", cur_x, 640);
        check("R1 y in reset", cur_y, 512);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 x after reset", cur_x, 640);
        check("R1 y after reset", cur_y, 512);
    endtask

    task automatic t_idle();
        dir_x = 1'b1; dir_y = 1'b0;
        repeat (20) @(negedge clk);
        check("R3 x idle", cur_x, 640);
        check("R3 y idle", cur_y, 512);
    endtask

    task automatic t_inc();
        dir_x = 1'b1; dir_y = 1'b1;
        pulse(3);
        check("R4 x up", cur_x, 643);
        check("R4 y up", cur_y, 515);
    endtask

    task automatic t_dec();
        dir_x = 1'b0; dir_y = 1'b0;
        pulse(5);
        check("R5 x down", cur_x, 638);
        check("R5 y down", cur_y, 510);
    endtask

    task automatic t_stop();
        hold_x = 1'b1; dir_y = 1'b1;
        pulse(4);
        check("R8 x held", cur_x, 638);
        check("R8 y moves", cur_y, 514);
        hold_x = 1'b0; hold_y = 1'b1; dir_x = 1'b1;
        pulse(2);
        check("R8 x moves", cur_x, 640);
        check("R8 y held", cur_y, 514);
        hold_y = 1'b0;
    endtask

    task automatic t_recentre();
        dir_x = 1'b1; dir_y = 1'b0;
        pulse(7);
        do_recentre();
        check("R2 x no tick", cur_x, 640);
        check("R2 y no tick", cur_y, 512);
        pulse(2);
        @(negedge clk) begin recenter = 1'b1; frame_tick = 1'b1; end
        @(negedge clk) begin recenter = 1'b0; frame_tick = 1'b0; end
        check("R2 x over tick", cur_x, 640);
        check("R2 y over tick", cur_y, 512);
    endtask

    task automatic t_wrap_x();
        hold_y = 1'b1; dir_x = 1'b1;
        pulse(639);
        check("R6 x at right edge", cur_x, 1279);
        pulse(1);
        check("R6 x wrap to 0", cur_x, 0);
        check("R9 y held in range", cur_y, 512);
        dir_x = 1'b0;
        pulse(1);
        check("R6 x wrap to 1279", cur_x, 1279);
        check("R9 x in range", int'(cur_x < 11'd1280), 1);
        hold_y = 1'b0;
        do_recentre();
    endtask

    task automatic t_wrap_y();
        hold_x = 1'b1; dir_y = 1'b1;
        pulse(511);
        check("R7 y at bottom edge", cur_y, 1023);
        pulse(1);
        check("R7 y wrap to 0", cur_y, 0);
        dir_y = 1'b0;
        pulse(1);
        check("R7 y wrap to 1023", cur_y, 1023);
        check("R8 x held during y wrap", cur_x, 640);
        hold_x = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle();
        t_inc();
        t_dec();
        t_stop();
        t_recentre();
        t_wrap_x();
        t_wrap_y();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule